// File: doc/BRIEF.md
# Debug Register Lock and Claim Tags

This block is a small slice of a processor debug unit's register file. It sits on a simple 32-bit register bus and holds three things. The first is a software lock that only a fixed 32-bit key can open. The second is a set of eight claim tags, which separate agents use to mark ownership of debug resources. The third is a generic guarded register that stands in for the rest of the debug registers. Writes go in through a strobe. Reads are combinational while the read strobe is high.

The lock exists to reduce accidental corruption of debug state. While it is engaged, writes to the claim tags and to the guarded register are dropped. The lock access location itself stays writable at all times, so a debugger can always open the lock again. The claim tags have two addresses, each reading back differently. One address sets tags and reports how many tags exist. The other clears tags and reports which tags are currently set.

Top module: `dbgLockSlice`

## Requirements
- R1: After reset the slice is locked, all claim tags are 0 and the guarded register holds 0. A read of lock status therefore returns 0x3.
- R2: A write of exactly 0xC5ACCE55 to the lock access address (0x3) unlocks the slice. Lock status bit 1 then reads 0 from the next cycle onward.
- R3: A write of any other value to the lock access address locks the slice. This includes a value that differs from the key in one bit.
- R4: The lock access address is write-only and reads 0. It accepts writes whether the slice is locked or unlocked.
- R5: While the slice is locked, writes to the guarded register (0x0), the claim set address (0x1) and the claim clear address (0x2) leave all stored state unchanged.
- R6: While the slice is locked, reads of the guarded register and the claim clear address still return the stored values.
- R7: A write to the claim set address sets each tag whose write bit is 1 and leaves tags whose write bit is 0 unchanged. A read of the claim set address always returns 0x000000FF.
- R8: A write to the claim clear address clears each tag whose write bit is 1 and leaves the others unchanged. A read of the claim clear address returns the eight tags in bits [7:0].
- R9: Bits [31:8] of both claim addresses read as zero, and the values written to those bits are ignored.
- R10: The lock status address (0x4) is read-only. Bit 0 always reads 1, meaning a lock is implemented. Bit 1 reads 1 when the slice is locked. Bit 2 reads 0, meaning 32-bit access. All other bits read 0.
- R11: Read data is zero when the read strobe is low and when the address is not mapped (0x5 to 0xF). A write takes effect on the next clock edge, so a read in the following cycle shows the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register word address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Read data, valid while rdEn is high |

## Verification
The key compare is driven with the exact key, with a value one bit away from the key, and again with the exact key while the slice is already locked. This shows that the check compares all 32 bits and that the lock access address is never gated.

Claim tags are written with mixed patterns that carry ones in bits [31:8]. Later set and clear writes overlap earlier ones. This separates a true write-one-to-set or write-one-to-clear update from a plain overwrite, and shows that the upper bits have no effect.

The same set, clear and guarded-register writes are repeated while locked, then the state is read back. This shows that the lock suppresses writes but not reads.

// File: rtl/dbgLockPkg.sv
package dbgLockPkg;
  localparam int ADDR_W = 4;

  // Word addresses of the slice
  localparam logic [ADDR_W-1:0] ADDR_SCRATCH  = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_CLAIMSET = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_CLAIMCLR = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_LOCKKEY  = 4'h3;
  localparam logic [ADDR_W-1:0] ADDR_LOCKSTAT = 4'h4;

  // Lock status bit positions
  localparam int STAT_IMPL_BIT   = 0;
  localparam int STAT_LOCKED_BIT = 1;
  localparam int STAT_WIDTH_BIT  = 2;

  typedef struct packed {
    logic setTags;
    logic clrTags;
    logic wrScratch;
  } ctrlStrobeT;
endpackage

// File: rtl/dbgLockCtrl.sv
module dbgLockCtrl
  import dbgLockPkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              isLocked,
  output ctrlStrobeT        strobes
);
  localparam logic [DATA_W-1:0] KEY_W = DATA_W'(UNLOCK_KEY);

  logic keyWrite;
  logic keyMatch;

  // The lock access address is never gated by the lock.
  assign keyWrite = wrEn && (addr == ADDR_LOCKKEY);
  assign keyMatch = (wrData == KEY_W);

  always_ff @(posedge clk) begin
    if (!rstN)         isLocked <= 1'b1;
    else if (keyWrite) isLocked <= !keyMatch;
  end

  always_comb begin
    strobes           = '0;
    strobes.wrScratch = wrEn && !isLocked && (addr == ADDR_SCRATCH);
    strobes.setTags   = wrEn && !isLocked && (addr == ADDR_CLAIMSET);
    strobes.clrTags   = wrEn && !isLocked && (addr == ADDR_CLAIMCLR);
  end
endmodule

// File: rtl/dbgLockDatapath.sv
module dbgLockDatapath
  import dbgLockPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_TAGS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobeT          strobes,
  input  logic                isLocked,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rdEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_TAGS-1:0] tagState,
  output logic [DATA_W-1:0]   scratchVal
);
  localparam logic [DATA_W-1:0] TAG_PRESENT = DATA_W'({NUM_TAGS{1'b1}});

  // Per-tag write-one-to-set / write-one-to-clear cells
  for (genvar g = 0; g < NUM_TAGS; g++) begin : gTag
    always_ff @(posedge clk) begin
      if (!rstN)
        tagState[g] <= 1'b0;
      else if (strobes.setTags && wrData[g])
        tagState[g] <= 1'b1;
      else if (strobes.clrTags && wrData[g])
        tagState[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  scratchVal <= '0;
    else if (strobes.wrScratch) scratchVal <= wrData;
  end

  logic [DATA_W-1:0] statusWord;
  always_comb begin
    statusWord                  = '0;
    statusWord[STAT_IMPL_BIT]   = 1'b1;
    statusWord[STAT_LOCKED_BIT] = isLocked;
    statusWord[STAT_WIDTH_BIT]  = 1'b0;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        ADDR_SCRATCH:  rdData = scratchVal;
        ADDR_CLAIMSET: rdData = TAG_PRESENT;
        ADDR_CLAIMCLR: rdData = DATA_W'(tagState);
        ADDR_LOCKSTAT: rdData = statusWord;
        default:       rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbgLockSlice.sv
module dbgLockSlice
  import dbgLockPkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          NUM_TAGS   = 8,
  parameter logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData
);
  ctrlStrobeT          strobes;
  logic                isLocked;
  logic [NUM_TAGS-1:0] tagState;
  logic [DATA_W-1:0]   scratchVal;

  dbgLockCtrl #(.DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .isLocked(isLocked), .strobes(strobes)
  );

  dbgLockDatapath #(.DATA_W(DATA_W), .NUM_TAGS(NUM_TAGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .isLocked(isLocked),
    .addr(addr), .rdEn(rdEn), .wrData(wrData), .rdData(rdData),
    .tagState(tagState), .scratchVal(scratchVal)
  );
endmodule

// File: rtl/dbgLockChecker.sv
module dbgLockChecker
  import dbgLockPkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          NUM_TAGS   = 8,
  parameter logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55
) (
  input logic                clk,
  input logic                rstN,
  input logic [3:0]          addr,
  input logic                wrEn,
  input logic [DATA_W-1:0]   wrData,
  input logic                rdEn,
  input logic [DATA_W-1:0]   rdData,
  input logic                isLocked,
  input logic [NUM_TAGS-1:0] tagState,
  input logic [DATA_W-1:0]   scratchVal
);
  logic guardedWr;
  assign guardedWr = wrEn && (addr == ADDR_SCRATCH || addr == ADDR_CLAIMSET || addr == ADDR_CLAIMCLR);

  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == ADDR_LOCKKEY && wrData == DATA_W'(UNLOCK_KEY) |=> !isLocked);

  assert_other_locks_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == ADDR_LOCKKEY && wrData != DATA_W'(UNLOCK_KEY) |=> isLocked);

  assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    isLocked && guardedWr |=> $stable(tagState) && $stable(scratchVal));

  assert_set_reads_ff_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && addr == ADDR_CLAIMSET |-> rdData == DATA_W'({NUM_TAGS{1'b1}}));

  assert_clr_upper_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && addr == ADDR_CLAIMCLR |-> rdData[DATA_W-1:NUM_TAGS] == '0);

  assert_status_layout_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && addr == ADDR_LOCKSTAT |-> rdData[STAT_IMPL_BIT] && !rdData[STAT_WIDTH_BIT]
      && rdData[STAT_LOCKED_BIT] == isLocked && rdData[DATA_W-1:3] == '0);

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);
endmodule

bind dbgLockSlice dbgLockChecker #(
  .DATA_W(DATA_W), .NUM_TAGS(NUM_TAGS), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .rdEn(rdEn), .rdData(rdData), .isLocked(isLocked),
  .tagState(tagState), .scratchVal(scratchVal)
);

// File: tb/sim_dbgLockSlice.sv
`timescale 1ns/1ps
module sim_dbgLockSlice;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dbgLockSlice u0 (.clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
                   .wrData(wrData), .rdEn(rdEn), .rdData(rdData));

  typedef struct packed {
    logic        isWr;
    logic [3:0]  a;
    logic [31:0] d;     // write data, or expected read data
    logic [7:0]  req;
  } vecT;

  localparam int NV = 27;
  localparam vecT VEC[NV] = '{
    '{1'b0, 4'h4, 32'h0000_0003, 8'd1},  // R1 status after reset
    '{1'b0, 4'h2, 32'h0000_0000, 8'd1},  // R1 tags zero
    '{1'b0, 4'h0, 32'h0000_0000, 8'd1},  // R1 scratch zero
    '{1'b1, 4'h0, 32'h0000_1234, 8'd5},  // R5 locked scratch write
    '{1'b0, 4'h0, 32'h0000_0000, 8'd5},
    '{1'b1, 4'h1, 32'h0000_000F, 8'd5},  // R5 locked set write
    '{1'b0, 4'h2, 32'h0000_0000, 8'd5},
    '{1'b1, 4'h3, 32'hC5AC_CE55, 8'd2},  // R2 unlock
    '{1'b0, 4'h4, 32'h0000_0001, 8'd2},
    '{1'b1, 4'h1, 32'hFFFF_FF05, 8'd9},  // R9 upper bits ignored
    '{1'b0, 4'h2, 32'h0000_0005, 8'd9},
    '{1'b1, 4'h1, 32'h0000_0030, 8'd7},  // R7 zeros keep tags
    '{1'b0, 4'h2, 32'h0000_0035, 8'd7},
    '{1'b0, 4'h1, 32'h0000_00FF, 8'd7},  // R7 set reads 0xFF
    '{1'b1, 4'h2, 32'hABCD_0011, 8'd8},  // R8 clear selected tags
    '{1'b0, 4'h2, 32'h0000_0024, 8'd8},
    '{1'b1, 4'h0, 32'hDEAD_BEEF, 8'd11}, // R11 write seen next cycle
    '{1'b0, 4'h0, 32'hDEAD_BEEF, 8'd11},
    '{1'b0, 4'h3, 32'h0000_0000, 8'd4},  // R4 lock access reads 0
    '{1'b1, 4'h3, 32'hC5AC_CE54, 8'd3},  // R3 near key locks
    '{1'b0, 4'h4, 32'h0000_0003, 8'd3},
    '{1'b0, 4'h0, 32'hDEAD_BEEF, 8'd6},  // R6 reads while locked
    '{1'b0, 4'h2, 32'h0000_0024, 8'd6},
    '{1'b1, 4'h2, 32'h0000_00FF, 8'd5},  // R5 locked clear write
    '{1'b0, 4'h2, 32'h0000_0024, 8'd5},
    '{1'b1, 4'h3, 32'hC5AC_CE55, 8'd4},  // R4 writable while locked
    '{1'b0, 4'h4, 32'h0000_0001, 8'd4}
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input int req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, input logic [31:0] exp, input int req);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b1; addr = a;
    #1 check(rdData, exp, req);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isWr) doWrite(VEC[i].a, VEC[i].d);
      else             doRead(VEC[i].a, VEC[i].d, int'(VEC[i].req));
    end

    // R11: unmapped address and idle read strobe give zero
    doRead(4'hF, 32'h0, 11);
    doRead(4'h5, 32'h0, 11);
    @(negedge clk);
    rdEn = 1'b0; addr = 4'h0;
    #1 check(rdData, 32'h0, 11);

    // R1: reset mid-run clears tags, scratch and relocks
    doWrite(4'h1, 32'h0000_00C3);
    doWrite(4'h0, 32'h5555_AAAA);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    doRead(4'h4, 32'h3, 1);
    doRead(4'h2, 32'h0, 1);
    doRead(4'h0, 32'h0, 1);

    // R3: unlock then relock with a zero write
    doWrite(4'h3, 32'hC5AC_CE55);
    doWrite(4'h3, 32'h0);
    doRead(4'h4, 32'h3, 3);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule